// File: doc/BRIEF.md
# GPIO Companion Register Controller

This peripheral is a small bank of 16-bit registers on a plain synchronous register bus. A single-cycle write strobe carries the address and data, and the read data follows the address combinationally. Most of the registers are plain storage for mode, card detect, card power, card control and three interrupt words. The block keeps no logic behind them. The card power register has one side effect. The card status register is read-only and holds a fixed value.

The rest of the block is a 16-line general-purpose output port. Software sets a direction mask and a level word. A level write is masked by the current direction. One cycle after a direction or level write, the block recomputes the driven vector as level AND direction. In that same cycle it raises a one-cycle toggle strobe on every bit that changed. Each external input line can force its level bit high or low. Such an event updates the stored level only. The outputs follow it at the next direction or level write.

This is a control-register interface, not a data stream, so the bus has no valid/ready pair. Every access completes in the cycle it is presented.

Top module: `gpio_companion_ctrl`

## Requirements
- R1: After reset every register reads 0x0000, except card status at offset 0x08, which reads 0x0002. `gpio_out` and `gpio_toggle` are zero.
- R2: Writes keep only the low 16 bits of `bus_wdata`. A write is read back unchanged at mode 0x00, card detect 0x04, card control 0x10, interrupt request 0x14, interrupt mask 0x18, interrupt status 0x1C, direction 0x20 and scratch 0x28.
- R3: Card status at offset 0x08 always reads 0x0002, and bus writes to it are ignored.
- R4: A write to card power at offset 0x0C stores the data. If data bit 7 is set, it stores the data ORed with 0x8040.
- R5: A write to the level register at offset 0x24 stores the data ANDed with the direction register as it stood before that write.
- R6: One clock edge after a write to offset 0x20 or 0x24 takes effect, `gpio_out` becomes stored level AND direction. No other cause changes `gpio_out`.
- R7: `gpio_toggle` is high for exactly one cycle, on exactly the bits where `gpio_out` changed at that edge. Otherwise it is zero.
- R8: When `gpio_in_evt[i]` is high at a clock edge, level bit i takes `gpio_in_val[i]`. This event does not change `gpio_out`.
- R9: When an input event and a level write hit the same bit at one edge, the input event decides that bit.
- R10: A read of any offset not listed above returns zero, including misaligned offsets. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data; upper 16 bits dropped |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| gpio_in_evt | input | 16 | Per-line input event strobe |
| gpio_in_val | input | 16 | Per-line level applied on an event |
| gpio_out | output | 16 | Driven output vector |
| gpio_toggle | output | 16 | One-cycle mark of output bits that changed |

## Verification
The assertions assume that reset is held across at least one rising edge before the first check. They also assume that `bus_addr`, `bus_we` and `bus_wdata` are stable around each edge. The power property further assumes that no second write to offset 0x0C lands between the write and the read that follows it. The bench drives every input on the falling edge and holds reset for several cycles. Each bus access lasts exactly one cycle, so these conditions always hold. The bench keeps a model of direction, level and the driven vector. It checks the toggle strobe against the difference between successive model outputs.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam int REG_W = 16;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_DETECT = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h08;
  localparam logic [7:0] OFS_POWER  = 8'h0C;
  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam logic [7:0] OFS_IREQ   = 8'h14;
  localparam logic [7:0] OFS_IMASK  = 8'h18;
  localparam logic [7:0] OFS_ISTAT  = 8'h1C;
  localparam logic [7:0] OFS_DIR    = 8'h20;
  localparam logic [7:0] OFS_LEVEL  = 8'h24;
  localparam logic [7:0] OFS_SCRAT  = 8'h28;

  localparam logic [REG_W-1:0] STATUS_FIXED = 16'h0002;
  localparam logic [REG_W-1:0] POWER_FORCE  = 16'h8040;
  localparam int               POWER_TRIG   = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_DETECT, SEL_STATUS, SEL_POWER, SEL_CTRL,
    SEL_IREQ, SEL_IMASK, SEL_ISTAT, SEL_DIR, SEL_LEVEL, SEL_SCRAT
  } reg_sel_e;
endpackage

// File: rtl/gcc_decode.sv
module gcc_decode
  import gcc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  logic [7:0] ofs;
  logic       high_zero;

  generate
    if (AW > 8) begin : g_wide
      assign ofs       = addr[7:0];
      assign high_zero = (addr[AW-1:8] == '0);
    end else begin : g_narrow
      assign ofs       = 8'(addr);
      assign high_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    if (high_zero) begin
      unique case (ofs)
        OFS_MODE:   sel = SEL_MODE;
        OFS_DETECT: sel = SEL_DETECT;
        OFS_STATUS: sel = SEL_STATUS;
        OFS_POWER:  sel = SEL_POWER;
        OFS_CTRL:   sel = SEL_CTRL;
        OFS_IREQ:   sel = SEL_IREQ;
        OFS_IMASK:  sel = SEL_IMASK;
        OFS_ISTAT:  sel = SEL_ISTAT;
        OFS_DIR:    sel = SEL_DIR;
        OFS_LEVEL:  sel = SEL_LEVEL;
        OFS_SCRAT:  sel = SEL_SCRAT;
        default:    sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gcc_regfile.sv
module gcc_regfile
  import gcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wd,
  output logic [REG_W-1:0] rd
);
  localparam int NSTORE = 7;

  logic [REG_W-1:0] store_q [NSTORE];
  reg_sel_e         slot_sel [NSTORE];

  assign slot_sel[0] = SEL_MODE;
  assign slot_sel[1] = SEL_DETECT;
  assign slot_sel[2] = SEL_POWER;
  assign slot_sel[3] = SEL_CTRL;
  assign slot_sel[4] = SEL_IREQ;
  assign slot_sel[5] = SEL_IMASK;
  assign slot_sel[6] = SEL_ISTAT;

  logic [REG_W-1:0] power_wd;
  assign power_wd = wd[POWER_TRIG] ? (wd | POWER_FORCE) : wd;

  genvar gi;
  generate
    for (gi = 0; gi < NSTORE; gi++) begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)
          store_q[gi] <= '0;
        else if (we && sel == slot_sel[gi])
          store_q[gi] <= (slot_sel[gi] == SEL_POWER) ? power_wd : wd;
      end
    end
  endgenerate

  always_comb begin
    rd = '0;
    for (int i = 0; i < NSTORE; i++)
      if (sel == slot_sel[i]) rd = store_q[i];
    if (sel == SEL_STATUS) rd = STATUS_FIXED;
  end
endmodule

// File: rtl/gcc_gpio_core.sv
module gcc_gpio_core
  import gcc_pkg::*;
#(
  parameter int N = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic         scr_we,
  input  logic [N-1:0] wd,
  input  logic [N-1:0] in_evt,
  input  logic [N-1:0] in_val,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] scr_q,
  output logic [N-1:0] out_q,
  output logic [N-1:0] tog_q
);
  logic [N-1:0] lvl_bus;
  logic [N-1:0] lvl_nxt;
  logic         recalc_q;

  assign lvl_bus = lvl_we ? (wd & dir_q) : lvl_q;

  genvar gb;
  generate
    for (gb = 0; gb < N; gb++) begin : g_bit
      assign lvl_nxt[gb] = in_evt[gb] ? in_val[gb] : lvl_bus[gb];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q    <= '0;
      lvl_q    <= '0;
      scr_q    <= '0;
      out_q    <= '0;
      tog_q    <= '0;
      recalc_q <= 1'b0;
    end else begin
      lvl_q    <= lvl_nxt;
      recalc_q <= dir_we | lvl_we;
      if (dir_we) dir_q <= wd;
      if (scr_we) scr_q <= wd;
      if (recalc_q) begin
        out_q <= lvl_q & dir_q;
        tog_q <= (lvl_q & dir_q) ^ out_q;
      end else begin
        tog_q <= '0;
      end
    end
  end
endmodule

// File: rtl/gpio_companion_ctrl.sv
module gpio_companion_ctrl
  import gcc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] gpio_in_evt,
  input  logic [REG_W-1:0] gpio_in_val,
  output logic [REG_W-1:0] gpio_out,
  output logic [REG_W-1:0] gpio_toggle
);
  reg_sel_e         sel;
  logic [REG_W-1:0] wd;
  logic [REG_W-1:0] rf_rd;
  logic [REG_W-1:0] dir_q;
  logic [REG_W-1:0] lvl_q;
  logic [REG_W-1:0] scr_q;
  logic             unused_hi;

  assign wd        = bus_wdata[REG_W-1:0];
  assign unused_hi = ^bus_wdata[BUS_W-1:REG_W];

  gcc_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  gcc_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .sel   (sel),
    .wd    (wd),
    .rd    (rf_rd)
  );

  gcc_gpio_core #(.N(REG_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_we (bus_we && sel == SEL_DIR),
    .lvl_we (bus_we && sel == SEL_LEVEL),
    .scr_we (bus_we && sel == SEL_SCRAT),
    .wd     (wd),
    .in_evt (gpio_in_evt),
    .in_val (gpio_in_val),
    .dir_q  (dir_q),
    .lvl_q  (lvl_q),
    .scr_q  (scr_q),
    .out_q  (gpio_out),
    .tog_q  (gpio_toggle)
  );

  always_comb begin
    unique case (sel)
      SEL_DIR:   bus_rdata = dir_q;
      SEL_LEVEL: bus_rdata = lvl_q;
      SEL_SCRAT: bus_rdata = scr_q;
      default:   bus_rdata = rf_rd;
    endcase
  end
endmodule

// File: rtl/gcc_checker.sv
module gcc_checker #(
  parameter int AW    = 8,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [15:0]      bus_rdata,
  input logic [15:0]      gpio_in_evt,
  input logic [15:0]      gpio_in_val,
  input logic [15:0]      gpio_out,
  input logic [15:0]      gpio_toggle
);
  logic mapped;
  logic gpio_wr;
  assign mapped = (bus_addr <= AW'(8'h28)) && (bus_addr[1:0] == 2'b00);
  assign gpio_wr = bus_we && (bus_addr == AW'(8'h20) || bus_addr == AW'(8'h24));

  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(8'h08)) |-> (bus_rdata == 16'h0002)); // R3

  AST_POWER_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_we && bus_addr == AW'(8'h0C) && bus_wdata[7]) && bus_addr == AW'(8'h0C))
    |-> (bus_rdata[15] && bus_rdata[6] && bus_rdata[7])); // R4

  AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gpio_wr, 2) |-> $stable(gpio_out)); // R6

  AST_TOGGLE_IS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_toggle == (gpio_out ^ $past(gpio_out))); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 16'h0000)); // R10
endmodule

bind gpio_companion_ctrl gcc_checker #(.AW(AW), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .gpio_in_evt (gpio_in_evt),
  .gpio_in_val (gpio_in_val),
  .gpio_out    (gpio_out),
  .gpio_toggle (gpio_toggle)
);

// File: tb/gpio_companion_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_companion_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] gpio_in_evt = '0;
  logic [15:0] gpio_in_val = '0;
  logic [15:0] gpio_out;
  logic [15:0] gpio_toggle;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] m_dir = '0, m_lvl = '0, m_out = '0;

  always #4 clk = ~clk;

  gpio_companion_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in_evt(gpio_in_evt),
    .gpio_in_val(gpio_in_val), .gpio_out(gpio_out), .gpio_toggle(gpio_toggle)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // gpio write followed by the recompute edge; checks R6 and R7
  task automatic gpio_wr(logic [7:0] a, logic [15:0] d);
    logic [15:0] nout;
    wr(a, {16'hDEAD, d});
    if (a == 8'h20) m_dir = d; else m_lvl = d & m_dir;
    nout = m_lvl & m_dir;
    check("R6 out held before recompute", gpio_out, m_out);
    @(negedge clk);
    check("R6 out after recompute", gpio_out, nout);
    check("R7 toggle bits", gpio_toggle, nout ^ m_out);
    m_out = nout;
    @(negedge clk);
    check("R7 toggle single cycle", gpio_toggle, 16'h0000);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0] rw_ofs [8] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h28};
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset values at every aligned offset
    for (int a = 0; a <= 8'h28; a += 4) begin
      rd(8'(a), v);
      check("R1 reset read", v, (a == 8) ? 16'h0002 : 16'h0000);
    end
    check("R1 reset out", gpio_out, 16'h0000);
    check("R1 reset toggle", gpio_toggle, 16'h0000);

    // R2: storage and truncation over several patterns
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] pat;
        pat = 16'h1234 * 16'(p + 1) + 16'(i * 16'h0101);
        wr(rw_ofs[i], {16'hFFFF, pat});
        rd(rw_ofs[i], v);
        check("R2 readback", v, pat);
      end
    end
    wr(8'h20, 32'h0); @(negedge clk);
    m_dir = 0; m_lvl = 0; m_out = 0;
    @(negedge clk);

    // R3: status ignores writes
    wr(8'h08, 32'h0000_FFFF);
    rd(8'h08, v); check("R3 status fixed", v, 16'h0002);

    // R4: power side effect sweep over bit 7 and neighbours
    for (int b = 0; b < 16; b++) begin
      logic [15:0] d;
      d = 16'(1 << b) | 16'h0100;
      wr(8'h0C, {16'h0, d});
      rd(8'h0C, v);
      check("R4 power store", v, d[7] ? (d | 16'h8040) : d);
    end

    // R5, R6, R7: direction and level sweeps
    for (int p = 0; p < 6; p++) begin
      logic [15:0] dd, ll;
      dd = 16'hF0F0 ^ 16'(p * 16'h1357);
      ll = 16'hAAAA ^ 16'(p * 16'h0F1E);
      gpio_wr(8'h20, dd);
      gpio_wr(8'h24, ll);
      rd(8'h24, v); check("R5 level masked", v, ll & dd);
    end
    gpio_wr(8'h20, 16'hFFFF);
    gpio_wr(8'h24, 16'hFFFF);
    gpio_wr(8'h20, 16'h00FF);
    gpio_wr(8'h24, 16'h0000);

    // R8: input events change level only
    gpio_wr(8'h20, 16'hFFFF);
    @(negedge clk);
    gpio_in_evt = 16'h0005; gpio_in_val = 16'h0001;
    @(negedge clk);
    gpio_in_evt = '0; gpio_in_val = '0;
    m_lvl = (m_lvl & ~16'h0005) | 16'h0001;
    rd(8'h24, v); check("R8 level from input", v, m_lvl);
    @(negedge clk);
    check("R8 out not updated", gpio_out, m_out);
    check("R8 no toggle", gpio_toggle, 16'h0000);
    gpio_wr(8'h20, 16'hFFFF);
    check("R8 out after dir write", gpio_out, m_lvl);

    // R9: input beats a same-cycle level write
    @(negedge clk);
    bus_addr = 8'h24; bus_we = 1'b1; bus_wdata = 32'h0000_FFFF;
    gpio_in_evt = 16'h0300; gpio_in_val = 16'h0100;
    @(negedge clk);
    bus_we = 1'b0; gpio_in_evt = '0; gpio_in_val = '0;
    rd(8'h24, v); check("R9 input priority", v, 16'hFDFF);

    // R10: unmapped reads and writes
    foreach (rw_ofs[i]) wr(rw_ofs[i], 32'h0000_5A5A);
    for (int a = 0; a < 64; a++) begin
      logic [7:0] ua;
      ua = (a < 32) ? 8'(8'h2C + a * 4) : 8'(a - 32);
      if (ua <= 8'h28 && ua[1:0] == 2'b00) continue;
      wr(ua, 32'h0000_FFFF);
      rd(ua, v); check("R10 unmapped read", v, 16'h0000);
    end
    foreach (rw_ofs[i]) begin
      rd(rw_ofs[i], v); check("R10 no side write", v, 16'h5A5A);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule